// File: doc/BRIEF.md
# Self-Timed Nonvolatile Write Engine

This block sits behind a serial front end and carries out already-decoded memory commands on an on-chip word array held in registers. It serves reads at once. It runs single-word write and erase, and whole-array write and erase, as one programming cycle that times itself. The cycle lasts a fixed number of system clock cycles set by a parameter. While the cycle runs, `busy` is high and every other command is refused. When the cycle ends, `ready` is raised so the front end can report completion.

A write-enable latch guards every programming command. The latch is clear after reset, so software must first issue an enable command. Reads ignore the latch. The organization input selects how the same storage is seen: 1024 words of 16 bits, or 2048 bytes. In byte view, address bit 0 picks the low or high half of a stored word.

Top module: `nvm_prog_engine`

## Requirements
- R1: Reset state: `busy`, `ready` and `rd_valid` are low, the enable latch is clear, and every stored bit is 1.
- R2: Op codes are NOP=0, READ=1, WREN=2, WRDIS=3, WRITE=4, ERASE=5, WRALL=6, ERALL=7. WREN sets the enable latch and WRDIS clears it. A programming command (codes 4 to 7) that is accepted while the latch is clear is dropped: `busy` stays low and no stored bit changes.
- R3: An accepted READ gives `rd_valid` high for one cycle, in the cycle after acceptance, with the addressed data on `rd_data`. This happens whatever the state of the latch.
- R4: WRITE stores `cmd_data` into the addressed word, replacing whatever value was there; no erase is needed first.
- R5: ERASE sets every bit of the addressed word to 1.
- R6: WRALL stores the pattern into every word, and ERALL sets every bit of the array to 1. In byte view, WRALL puts the low byte of `cmd_data` into both halves of each word.
- R7: An enabled programming command raises `busy` from the cycle after acceptance for exactly PROG_CYCLES cycles. The array takes the new value on the edge where `busy` falls.
- R8: While `busy` is high, every command is ignored. This includes reads, enable and disable commands, and a command presented on the last busy cycle.
- R9: `ready` rises on the edge where `busy` falls. It stays high until the next accepted command, and is never high together with `busy`.
- R10: With `org_wide`=0, the word index is `cmd_addr[10:1]` and `cmd_addr[0]` selects the low (0) or high (1) byte. WRITE and ERASE change only that byte. READ returns the byte in `rd_data[7:0]`, with zeros above it.
- R11: With `org_wide`=1, the word index is `cmd_addr[9:0]`, and `cmd_addr[10]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| org_wide | input | 1 | 1: 16-bit words, 0: byte view; sampled with each command |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Decoded operation code |
| cmd_addr | input | 11 | Word or byte address |
| cmd_data | input | 16 | Write pattern |
| busy | output | 1 | Programming cycle running |
| ready | output | 1 | Last programming cycle completed |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |

## Verification
Two events can fall in the same cycle: the end of the programming cycle and a new command. The bench times a command to arrive on the final busy cycle, one edge before `busy` drops. It then requires that command to be dropped, that `busy` is low and `ready` high on the next edge, and that a read issued right after returns the freshly committed data. A read sent to the scoreboard while busy has no expected entry, so any `rd_valid` it produced would be reported.

// File: rtl/nvm_eng_pkg.sv
package nvm_eng_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WREN  = 3'd2,
    OP_WRDIS = 3'd3,
    OP_WRITE = 3'd4,
    OP_ERASE = 3'd5,
    OP_WRALL = 3'd6,
    OP_ERALL = 3'd7
  } nvm_op_e;

  function automatic logic op_programs(nvm_op_e op);
    return op inside {OP_WRITE, OP_ERASE, OP_WRALL, OP_ERALL};
  endfunction

  function automatic logic op_fills_ones(nvm_op_e op);
    return op inside {OP_ERASE, OP_ERALL};
  endfunction

  function automatic logic op_whole_array(nvm_op_e op);
    return op inside {OP_WRALL, OP_ERALL};
  endfunction
endpackage

// File: rtl/nvm_wel.sv
module nvm_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_o <= 1'b0;
    else if (clr_i) en_o <= 1'b0;
    else if (set_i) en_o <= 1'b1;
  end
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int PROG_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic accept_i,
  output logic busy_o,
  output logic finish_o,
  output logic ready_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] remain_q;

  assign finish_o = busy_o && (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      remain_q <= '0;
      ready_o  <= 1'b0;
    end else if (start_i) begin
      busy_o   <= 1'b1;
      remain_q <= CW'(PROG_CYCLES - 1);
      ready_o  <= 1'b0;
    end else if (busy_o) begin
      if (remain_q == '0) begin
        busy_o  <= 1'b0;
        ready_o <= 1'b1;
      end else begin
        remain_q <= remain_q - 1'b1;
      end
    end else if (accept_i) begin
      ready_o <= 1'b0;
    end
  end

  // busy and ready are never high in the same cycle
  p_busy_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && ready_o)) else $error("busy and ready both high");
  p_ready_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ready_o) else $error("ready missing at end of cycle");
endmodule

// File: rtl/nvm_word_array.sv
module nvm_word_array #(
  parameter int WORD_AW = 10,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic               all_i,
  input  logic               ones_i,
  input  logic               wide_i,
  input  logic [WORD_AW:0]   addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               rd_wide_i,
  input  logic [WORD_AW:0]   rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int WORDS  = 1 << WORD_AW;
  localparam int ADDR_W = WORD_AW + 1;
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] mem [WORDS];

  function automatic logic [WORD_AW-1:0] word_of(logic [ADDR_W-1:0] a, logic wide);
    return wide ? a[WORD_AW-1:0] : a[ADDR_W-1:1];
  endfunction

  function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old, logic [DATA_W-1:0] d,
                                              logic wide, logic hi, logic ones, logic all);
    logic [DATA_W-1:0] fill;
    fill = ones ? '1 : (wide ? d : {d[BYTE_W-1:0], d[BYTE_W-1:0]});
    if (wide || all) return fill;
    return hi ? {fill[DATA_W-1:BYTE_W], old[BYTE_W-1:0]}
              : {old[DATA_W-1:BYTE_W], fill[BYTE_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] pick(logic [DATA_W-1:0] w, logic wide, logic hi);
    if (wide) return w;
    return {{(DATA_W-BYTE_W){1'b0}}, hi ? w[DATA_W-1:BYTE_W] : w[BYTE_W-1:0]};
  endfunction

  logic [WORD_AW-1:0] wr_idx;
  assign wr_idx = word_of(addr_i, wide_i);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    assign hit = commit_i && (all_i || (wr_idx == WORD_AW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '1;
      else if (hit) mem[g] <= merge(mem[g], data_i, wide_i, addr_i[0], ones_i, all_i);
    end
  end

  assign rd_data_o = pick(mem[word_of(rd_addr_i, rd_wide_i)], rd_wide_i, rd_addr_i[0]);
endmodule

// File: rtl/nvm_prog_engine.sv
module nvm_prog_engine #(
  parameter int WORD_AW     = 10,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                org_wide,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [WORD_AW:0]    cmd_addr,
  input  logic [DATA_W-1:0]   cmd_data,
  output logic                busy,
  output logic                ready,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);
  import nvm_eng_pkg::*;
  localparam int LW = $clog2(PROG_CYCLES + 1) + 1;

  nvm_op_e           op;
  logic              accept, wel_en, prog_start, prog_finish;
  logic [DATA_W-1:0] arr_rd;
  nvm_op_e           p_op;
  logic [WORD_AW:0]  p_addr;
  logic [DATA_W-1:0] p_data;
  logic              p_wide;

  assign op         = nvm_op_e'(cmd_op);
  assign accept     = cmd_valid && !busy;
  assign prog_start = accept && op_programs(op) && wel_en;

  nvm_wel i_wel (
    .clk(clk), .rst_n(rst_n),
    .set_i(accept && op == OP_WREN),
    .clr_i(accept && op == OP_WRDIS),
    .en_o(wel_en)
  );

  nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .start_i(prog_start), .accept_i(accept),
    .busy_o(busy), .finish_o(prog_finish), .ready_o(ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_op   <= OP_NOP;
      p_addr <= '0;
      p_data <= '0;
      p_wide <= 1'b1;
    end else if (prog_start) begin
      p_op   <= op;
      p_addr <= cmd_addr;
      p_data <= cmd_data;
      p_wide <= org_wide;
    end
  end

  nvm_word_array #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) i_array (
    .clk(clk), .rst_n(rst_n),
    .commit_i(prog_finish), .all_i(op_whole_array(p_op)), .ones_i(op_fills_ones(p_op)),
    .wide_i(p_wide), .addr_i(p_addr), .data_i(p_data),
    .rd_wide_i(org_wide), .rd_addr_i(cmd_addr), .rd_data_o(arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept && op == OP_READ;
      if (accept && op == OP_READ) rd_data <= arr_rd;
    end
  end

  // independent busy run-length counter for the timing checks
  logic [LW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_run_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == LW'(PROG_CYCLES)) else $error("busy run length wrong");
  p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < LW'(PROG_CYCLES)) else $error("busy too long");
  p_start_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel_en)) else $error("programming without enable");
  p_no_read_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid) else $error("read served while busy");
  p_read_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && cmd_op == 3'd1)) else $error("spurious read data");
endmodule

// File: tb/test_nvm_prog_engine.sv
module test_nvm_prog_engine;
  import nvm_eng_pkg::*;
  localparam int PROG = 8;

  logic clk = 1'b0, rst_n = 1'b0, org_wide = 1'b1, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [10:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic busy, ready, rd_valid;
  logic [15:0] rd_data;

  int checks = 0, errors = 0;
  logic [15:0] mdl [1024];
  bit wel_m = 0;
  logic [15:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  nvm_prog_engine #(.PROG_CYCLES(PROG)) i_nvm_prog_engine (
    .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .busy(busy), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(int a, bit wide);
    logic [15:0] w;
    if (wide) return mdl[a % 1024];
    w = mdl[(a / 2) % 1024];
    return (a % 2 == 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  function automatic void mapply(nvm_op_e op, int a, logic [15:0] d, bit wide);
    logic [15:0] v;
    int idx;
    if (op == OP_WRALL || op == OP_ERALL) begin
      v = (op == OP_ERALL) ? 16'hFFFF : (wide ? d : {d[7:0], d[7:0]});
      for (int i = 0; i < 1024; i++) mdl[i] = v;
    end else begin
      v = (op == OP_ERASE) ? 16'hFFFF : d;
      if (wide) mdl[a % 1024] = v;
      else begin
        idx = (a / 2) % 1024;
        if (a % 2 == 1) mdl[idx][15:8] = v[7:0];
        else            mdl[idx][7:0]  = v[7:0];
      end
    end
  endfunction

  task automatic drive(nvm_op_e op, int a, logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = 11'(a); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_read(int a, string tag);
    exp_q.push_back(mread(a, org_wide));
    tag_q.push_back(tag);
    drive(OP_READ, a, '0);
  endtask

  task automatic do_cfg(nvm_op_e op);
    drive(op, 0, '0);
    if (op == OP_WREN) wel_m = 1;
    if (op == OP_WRDIS) wel_m = 0;
  endtask

  task automatic do_prog(nvm_op_e op, int a, logic [15:0] d, string tag);
    int n = 0;
    drive(op, a, d);
    if (wel_m) begin
      while (busy && n < 4 * PROG) begin n++; @(negedge clk); end
      chk(n == PROG, {"R7 busy length ", tag}, 16'(n), 16'(PROG));
      chk(ready == 1'b1, "R9 ready after cycle", 16'(ready), 16'h1);
      mapply(op, a, d, org_wide);
    end else begin
      repeat (2) begin
        chk(busy == 1'b0, {"R2 dropped while disabled ", tag}, 16'(busy), 16'h0);
        @(negedge clk);
      end
    end
  endtask

  // monitor: pops expected read data in order
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected rd_valid", rd_data, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mdl[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(busy == 0 && ready == 0 && rd_valid == 0, "R1 outputs in reset", {busy, ready, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && ready == 0 && rd_valid == 0, "R1 outputs after reset", {busy, ready, rd_valid}, 0);
    do_read(0, "R1 erased contents at reset");
    do_read(1023, "R1 erased contents at reset top");
    // R2: latch clear after reset, programming dropped
    do_prog(OP_WRITE, 5, 16'h1234, "write");
    do_prog(OP_ERALL, 0, 16'h0, "eral");
    do_read(5, "R2 word unchanged by dropped write");
    do_cfg(OP_WREN);
    // R4 write and overwrite without erase
    do_prog(OP_WRITE, 5, 16'h1234, "write");
    do_read(5, "R4 write stored");
    chk(ready == 0, "R9 ready cleared by next command", 16'(ready), 16'h0);
    do_prog(OP_WRITE, 5, 16'h00F0, "overwrite");
    do_read(5, "R4 overwrite without erase");
    do_read(6, "R4 neighbour untouched");
    // R5 erase
    do_prog(OP_ERASE, 5, 16'h0, "erase");
    do_read(5, "R5 erase to ones");
    // R10 byte view
    do_prog(OP_WRITE, 5, 16'h0000, "clear 5");
    org_wide = 1'b0;
    do_prog(OP_WRITE, 11, 16'hAB3C, "byte hi");
    do_read(11, "R10 high byte read");
    do_read(10, "R10 low byte kept");
    do_prog(OP_ERASE, 10, 16'h0, "byte erase lo");
    do_read(10, "R10 erase low byte only");
    org_wide = 1'b1;
    do_read(5, "R10 word view of byte writes");
    // R11 bit 10 ignored in wide view
    do_read(5 + 1024, "R11 address bit 10 ignored");
    // R6 whole-array operations
    do_prog(OP_WRALL, 0, 16'hA5C3, "wral");
    do_read(0, "R6 write-all word 0");
    do_read(1023, "R6 write-all last word");
    org_wide = 1'b0;
    do_prog(OP_WRALL, 3, 16'h775A, "wral byte");
    do_read(2047, "R6 byte write-all high byte");
    org_wide = 1'b1;
    do_read(512, "R6 byte write-all word view");
    do_prog(OP_ERALL, 0, 16'h0, "eral");
    do_read(300, "R6 erase-all");
    // R8 commands ignored while busy
    drive(OP_WRITE, 7, 16'h1111);
    chk(busy == 1, "R7 busy after accept", 16'(busy), 16'h1);
    drive(OP_READ, 7, '0);
    drive(OP_WRITE, 9, 16'h2222);
    drive(OP_WRDIS, 0, '0);
    while (busy) @(negedge clk);
    mapply(OP_WRITE, 7, 16'h1111, 1);
    do_read(9, "R8 write during busy ignored");
    do_read(7, "R8 first write committed");
    do_prog(OP_WRITE, 9, 16'h3333, "after ignored disable");
    do_read(9, "R8 disable during busy ignored");
    // same cycle: command on the last busy cycle vs end of cycle
    drive(OP_WRITE, 20, 16'hBEEF);
    repeat (PROG - 1) @(negedge clk);
    chk(busy == 1, "R7 last busy cycle", 16'(busy), 16'h1);
    cmd_valid = 1'b1; cmd_op = OP_WRITE; cmd_addr = 11'd21; cmd_data = 16'h0BAD;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 0, "R7 busy ends after PROG cycles", 16'(busy), 16'h0);
    chk(ready == 1, "R9 ready at end", 16'(ready), 16'h1);
    mapply(OP_WRITE, 20, 16'hBEEF, 1);
    do_read(20, "R7 commit visible right after cycle");
    do_read(21, "R8 command on last busy cycle dropped");
    // R2 disable then R3 read with latch clear
    do_cfg(OP_WRDIS);
    do_prog(OP_WRITE, 20, 16'h0000, "after disable");
    do_read(20, "R3 read served with latch clear");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads answered", 16'(exp_q.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule